// File: doc/BRIEF.md
# Serial Daisy-Chain Crosspoint Programmer

This block is the control side of an 8-output video crosspoint in its serial programming mode. A host clocks the whole switch configuration in one bit at a time. Each rising edge of the already-gated write strobe pushes one bit into a 32-bit master shift chain. The chain's top bit is brought out as a serial output, so several blocks can be wired in series and loaded from one data line.

The chain holds one 4-bit field per output. When a transfer event occurs, every field is decoded and applied to that output's slave state. The slave state is a selection value and an enable bit. A field can pick one of eight inputs, tie the output to ground, enable the output while grounding it, or disable the output. Disabling an output also drops its input choice.

The transfer event depends on a strap. With edge mode set, it is the LATCH rising edge. With edge mode clear, transfer happens on every clock while LATCH is low. The write strobe and LATCH are sampled in the system clock domain. An edge counts when a signal is sampled high on one clock edge and was low on the clock edge before.

Top module: `xpt_serial_prog`

## Requirements
- R1: On a clock where a write rising edge is detected, the chain shifts by one toward its top and `ser_in` enters bit 0; on any other clock the chain, and hence `ser_out`, holds.
- R2: `ser_out` is chain bit 31 and changes on the same clock as the shift, so a second instance whose `ser_in` is fed from it receives the bit leaving the first.
- R3: Field order is fixed: output k is decoded from chain bits [31-4k : 28-4k]. The first bit shifted in ends up as bit 3 of output 0's field after 32 shifts, and the 32nd bit as bit 0 of output 7's field.
- R4: With `edge_mode`=1, the slave state changes only on a clock where a LATCH rising edge is detected, and uses the chain contents as they stood before that clock's shift.
- R5: With `edge_mode`=0, the decoded chain is applied on every clock where `latch_i` is sampled 0, and the slave state holds while it is 1.
- R6: Codes 0 to 7 set the output's selection to that input number, and code 8 sets it to 8 (ground); neither code changes the enable bit.
- R7: Code 9 sets the enable bit and sets the selection to 8 (ground).
- R8: Code 10 clears the enable bit and sets the selection to 8 (ground), dropping the previous input.
- R9: Codes 11 to 15 leave that output's selection and enable bit unchanged.
- R10: After reset, all enable bits are 0, all selections are 0 and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_i | input | 1 | Gated write strobe; its rising edge shifts one bit |
| ser_in | input | 1 | Serial data into chain bit 0 |
| latch_i | input | 1 | Transfer control for the slave stage |
| edge_mode | input | 1 | Strap: 1 = transfer on LATCH rise, 0 = transfer while LATCH low |
| ser_out | output | 1 | Chain bit 31, for cascading |
| sel_o | output | 32 | Selection per output, output k at bits [4k+3:4k]; 0..7 = input, 8 = ground |
| en_o | output | 8 | Enable bit per output, output k at bit k |

## Verification
The properties assume that `wr_i`, `latch_i` and `ser_in` are synchronous to `clk` and that each high or low level of the write strobe and of LATCH lasts at least one clock. Otherwise an edge could be missed between samples. They also assume that `edge_mode` changes only while LATCH is held high, so that a strap change never creates a transfer event by itself. The stimulus drives every input on the falling clock edge and holds each strobe level for a full cycle. It toggles the strap only with LATCH high. Two instances are chained, so the cascade path is checked against a behavioural model on every clock.

// File: rtl/xpt_pkg.sv
// Package: shared widths, field code values and the field-decode function
// for the serial crosspoint programmer.
// Assumes four-bit fields and eight selectable inputs.
package xpt_pkg;

    localparam int FIELD_W = 4;
    localparam int NUM_IN  = 8;

    localparam logic [FIELD_W-1:0] CODE_GND  = FIELD_W'(NUM_IN);
    localparam logic [FIELD_W-1:0] CODE_ENGD = FIELD_W'(NUM_IN + 1);
    localparam logic [FIELD_W-1:0] CODE_OFF  = FIELD_W'(NUM_IN + 2);

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_PICK  = 2'd1,
        ACT_ENGND = 2'd2,
        ACT_OFF   = 2'd3
    } slot_act_e;

    // Map one field code to the action taken on its output.
    function automatic slot_act_e field_action(input logic [FIELD_W-1:0] code);
        if (code <= CODE_GND)       return ACT_PICK;
        else if (code == CODE_ENGD) return ACT_ENGND;
        else if (code == CODE_OFF)  return ACT_OFF;
        else                        return ACT_KEEP;
    endfunction

endpackage

// File: rtl/xpt_edge_det.sv
// Rising-edge detector for a signal already synchronous to clk.
// It flags a clock where the signal is sampled high after a low sample.
// Assumes every level lasts at least one clock.
module xpt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    // Remember the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/xpt_shift_chain.sv
// Master shift chain: on shift_en the data moves one place toward the top
// bit and din fills bit 0. The top bit is the cascade output.
// Assumes shift_en is a one-cycle pulse per bit.
module xpt_shift_chain #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             dout
);

    // Shift one bit in per enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], din};
    end

    assign dout = q[WIDTH-1];

endmodule

// File: rtl/xpt_out_slot.sv
// Slave state of one output: its selection value and its enable bit.
// On load, the field code is decoded and applied. Invalid codes are ignored.
// Assumes code is stable on the clock where load is high.
module xpt_out_slot
    import xpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] code,
    output logic [FIELD_W-1:0] sel,
    output logic               en
);

    slot_act_e act;

    assign act = field_action(code);

    // Apply the decoded action to selection and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            en  <= 1'b0;
        end else if (load) begin
            unique case (act)
                ACT_PICK:  sel <= code;
                ACT_ENGND: begin
                    sel <= CODE_GND;
                    en  <= 1'b1;
                end
                ACT_OFF: begin
                    sel <= CODE_GND;
                    en  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xpt_serial_prog.sv
// Top: serial daisy-chain programmer for the crosspoint control state.
// Write rises shift the master chain. Transfer events decode every field
// into the per-output slave state, in edge or level mode.
// Assumes wr_i and latch_i are synchronous to clk. Assumes edge_mode
// changes only while latch_i is high.
module xpt_serial_prog
    import xpt_pkg::*;
#(
    parameter int NOUT = 8,
    parameter int FW   = FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               ser_in,
    input  logic               latch_i,
    input  logic               edge_mode,
    output logic               ser_out,
    output logic [NOUT*FW-1:0] sel_o,
    output logic [NOUT-1:0]    en_o
);

    localparam int CHAIN_W = NOUT * FW;

    logic               wr_rise;
    logic               latch_rise;
    logic               latch_evt;
    logic [CHAIN_W-1:0] chain_q;

    xpt_edge_det u_wr_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (wr_i),
        .rise_o (wr_rise)
    );

    xpt_edge_det u_latch_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (latch_i),
        .rise_o (latch_rise)
    );

    // Transfer on LATCH rise in edge mode, or while LATCH is low in level mode.
    assign latch_evt = edge_mode ? latch_rise : ~latch_i;

    xpt_shift_chain #(.WIDTH(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (wr_rise),
        .din      (ser_in),
        .q        (chain_q),
        .dout     (ser_out)
    );

    // One slave slot per output. Output 0 takes the field shifted in first.
    for (genvar k = 0; k < NOUT; k++) begin : g_slot
        localparam int HI = CHAIN_W - 1 - k * FW;
        xpt_out_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (latch_evt),
            .code  (chain_q[HI -: FW]),
            .sel   (sel_o[k*FW +: FW]),
            .en    (en_o[k])
        );
    end

endmodule

// File: rtl/xpt_serial_prog_chk.sv
// Checker for xpt_serial_prog, attached by bind. It relates the detected
// strobes, the chain and the slave outputs over time.
// Assumes reset is asserted at the first clock edge.
module xpt_serial_prog_chk
    import xpt_pkg::*;
#(
    parameter int NOUT = 8,
    parameter int FW   = FIELD_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_rise,
    input logic               latch_evt,
    input logic [NOUT*FW-1:0] chain_q,
    input logic               ser_out,
    input logic [NOUT*FW-1:0] sel_o,
    input logic [NOUT-1:0]    en_o
);

    // R1: without a write rise the cascade bit holds.
    p_shift_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rise |=> $stable(ser_out));

    // R2: after a shift, the cascade bit is the old second-from-top bit.
    p_cascade_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> ser_out == $past(chain_q[NOUT*FW-2]));

    // R4 / R5: the slave state changes only on a transfer event.
    p_slave_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_evt |=> ($stable(sel_o) && $stable(en_o)));

    // R10: reset clears enables, selections and the cascade bit.
    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (en_o == '0 && sel_o == '0 && !ser_out));

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        // R7: an output that turns on is grounded.
        p_enable_grounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_o[k]) |-> sel_o[k*FW +: FW] == CODE_GND);

        // R8: an output that turns off has forgotten its input.
        p_disable_forgets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_o[k]) |-> sel_o[k*FW +: FW] == CODE_GND);

        // R6: a selection is always an input number or ground.
        p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sel_o[k*FW +: FW] <= CODE_GND);
    end

endmodule

bind xpt_serial_prog xpt_serial_prog_chk #(.NOUT(NOUT), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rise   (wr_rise),
    .latch_evt (latch_evt),
    .chain_q   (chain_q),
    .ser_out   (ser_out),
    .sel_o     (sel_o),
    .en_o      (en_o)
);

// File: tb/test_xpt_serial_prog.sv
`timescale 1ns/1ps
// Bench: two chained instances against a behavioural queue model,
// compared on every clock, plus directed checks at phase ends.
module test_xpt_serial_prog;

    localparam int NOUT = 8;
    localparam int W    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, sdi = 1'b0, lat = 1'b1, edge_m = 1'b1;
    logic so_a, so_b;
    logic [W-1:0]    sel_a, sel_b;
    logic [NOUT-1:0] en_a, en_b;

    always #2.5 clk = ~clk;

    xpt_serial_prog i_xpt_serial_prog (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .ser_in(sdi), .latch_i(lat),
        .edge_mode(edge_m), .ser_out(so_a), .sel_o(sel_a), .en_o(en_a));

    xpt_serial_prog i_xpt_serial_prog_b (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .ser_in(so_a), .latch_i(lat),
        .edge_mode(edge_m), .ser_out(so_b), .sel_o(sel_b), .en_o(en_b));

    // Model state: queue front is the oldest bit (the cascade bit).
    bit qa[$];
    bit qb[$];
    int ms[2][NOUT];
    int me[2][NOUT];
    bit wp, lp;
    int compared = 0, mismatched = 0;
    string tag = "R10";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int fld(bit q[$], int k);
        int v = 0;
        for (int b = 0; b < 4; b++) v = (v << 1) | int'(q[4*k + b]);
        return v;
    endfunction

    function automatic logic [31:0] pk_sel(int d);
        logic [31:0] r = '0;
        for (int k = 0; k < NOUT; k++) r[4*k +: 4] = 4'(ms[d][k]);
        return r;
    endfunction

    function automatic logic [31:0] pk_en(int d);
        logic [31:0] r = '0;
        for (int k = 0; k < NOUT; k++) r[k] = me[d][k][0];
        return r;
    endfunction

    task automatic apply_all();
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < NOUT; k++) begin
                int c = (d == 0) ? fld(qa, k) : fld(qb, k);
                if (c <= 8) ms[d][k] = c;
                else if (c == 9) begin ms[d][k] = 8; me[d][k] = 1; end
                else if (c == 10) begin ms[d][k] = 8; me[d][k] = 0; end
            end
        end
    endtask

    // Model update on each edge, then comparison shortly after it.
    always @(posedge clk) begin
        bit wr_r, l_evt, a_front;
        if (!rst_n) begin
            qa = {}; qb = {};
            for (int i = 0; i < W; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < NOUT; k++) begin ms[d][k] = 0; me[d][k] = 0; end
            wp = 1'b0; lp = 1'b0;
        end else begin
            wr_r  = wr && !wp;
            l_evt = edge_m ? (lat && !lp) : !lat;
            if (l_evt) apply_all();
            if (wr_r) begin
                a_front = qa[0];
                qb.push_back(a_front); void'(qb.pop_front());
                qa.push_back(sdi);     void'(qa.pop_front());
            end
            wp = wr; lp = lat;
        end
        #1;
        chk("ser_out A (R1)", {31'd0, so_a}, {31'd0, qa[0]});
        chk("ser_out B cascade (R2)", {31'd0, so_b}, {31'd0, qb[0]});
        chk("sel A", sel_a, pk_sel(0));
        chk("en A", {24'd0, en_a}, pk_en(0));
        chk("sel B", sel_b, pk_sel(1));
        chk("en B", {24'd0, en_b}, pk_en(1));
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic shift_bit(bit b);
        @(negedge clk); sdi = b; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    // R3: bit 31 of the word (output 0 field bit 3) goes first.
    task automatic load(logic [31:0] w);
        for (int i = 31; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic load_pair(logic [31:0] wa, logic [31:0] wb);
        load(wb);
        load(wa);
    endtask

    task automatic pulse_latch();
        @(negedge clk); lat = 1'b0;
        @(negedge clk); lat = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R10";
        chk("reset en", {24'd0, en_a}, 32'd0);
        chk("reset sel", sel_a, 32'd0);
        chk("reset ser_out", {31'd0, so_a}, 32'd0);

        tag = "R4";
        load_pair(32'h99999999, 32'h99999999);
        chk("no transfer before latch rise", {24'd0, en_a}, 32'd0);
        tag = "R7";
        pulse_latch();
        chk("enable-ground en", {24'd0, en_a}, 32'hFF);
        chk("enable-ground sel", sel_a, 32'h88888888);

        tag = "R3";
        load_pair(32'h01234567, 32'h76543210);
        pulse_latch();
        chk("field order sel A", sel_a, 32'h76543210);
        chk("field order sel B", sel_b, 32'h01234567);
        tag = "R6";
        chk("picks keep enable", {24'd0, en_a}, 32'hFF);

        tag = "R8";
        load_pair(32'hABCDEF83, 32'hABCDEF83);
        pulse_latch();
        chk("disable clears out0", {24'd0, en_a}, 32'hFE);
        tag = "R9";
        chk("invalid codes ignored", sel_a, 32'h38543218);

        tag = "R5";
        @(negedge clk); edge_m = 1'b0;
        load_pair(32'h52222222, 32'h52222222);
        chk("level mode holds while high", sel_a, 32'h38543218);
        @(negedge clk); lat = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("level transfer sel", sel_a, 32'h22222225);
        tag = "R6";
        chk("pick on disabled keeps off", {24'd0, en_a}, 32'hFE);
        tag = "R5";
        for (int i = 0; i < 12; i++) shift_bit(i[0]);
        @(negedge clk); lat = 1'b1;
        tag = "R1";
        for (int i = 0; i < 8; i++) shift_bit(i[1]);
        repeat (4) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule